// File: doc/BRIEF.md
# Pre/Post-Trigger Unit Capture Buffer

This block records a byte stream made of fixed-size units, such as cells or transmission frames, into a circular store. It keeps that record around a trigger. Each unit opens with a start-of-unit strobe. Its bytes are written into one slot of the ring, and the slot pointer moves on once the last byte of the unit has been written. When the capture finishes, the writes stop and a done flag rises. The store can then be read by unit and byte.

There are two capture modes. In manual mode, a user request is the trigger, and a full depth of units from the trigger onwards is kept. In event mode, a trigger is accepted only once half the depth has been recorded. Half the depth of older units is kept ahead of the trigger and half the depth is stored after it. Event mode can be triggered in three ways:

- a set of enabled event flags;
- a change in a selected overhead byte, ignoring the bits cleared in a mask;
- an exact match of that selected byte against a programmed value.

A re-arm pulse starts a fresh capture.

Top module: `cap_buffer`

## Requirements
- R1: After reset, `done` is 0, `trig_idx` is 0 and `rd_data` is 0.
- R2: A byte is stored only when `din_valid` is high and either `din_sou` is high or the current unit was opened by `din_sou` and has not reached its last byte. A unit is complete after `UNIT_BYTES` bytes. Valid bytes outside an open unit are dropped. A `din_sou` in the middle of a unit restarts the same slot at byte 0.
- R3: With `mode_event`=0, a `man_trig` pulse arms the post-trigger phase, and `done` rises after the unit of the trigger and the following `DEPTH-1` units have completed. The trigger unit is then at read address 0.
- R4: With `mode_event`=1, triggers are ignored until at least `DEPTH/2` units have completed since arming. After an accepted trigger, `done` rises once `DEPTH/2` units, counting the trigger unit, have completed. The trigger unit is then at read address `DEPTH/2`, with the `DEPTH/2` earlier units below it.
- R5: In event mode, an event trigger is any bit set in both `evt_flags` and `evt_en`, and `man_trig` has no effect. In manual mode, event flags and overhead-byte triggers have no effect.
- R6: When `chg_en` is 1, a tap sample at `sel_pos` triggers if `(ovh_byte ^ previous sample at sel_pos) & chg_mask` is nonzero. The first sample after arming has nothing to compare against.
- R7: When `val_en` is 1, a tap sample triggers when `ovh_pos == sel_pos` and `ovh_byte == match_val`. Samples at other positions never trigger.
- R8: Once `done` is 1, no byte is written and `done` stays 1 until `arm`. `arm` clears `done` and restarts filling from slot 0.
- R9: Read address (`rd_unit`, `rd_byte`) 0 is byte 0 of the oldest stored unit, and `rd_unit` counts toward newer units. `rd_data` shows the addressed byte one clock after the address is presented.
- R10: `trig_idx` holds the ring slot of the unit being written when the trigger was accepted, and it holds that value until the next accepted trigger.
- R11: Triggers arriving after one has been accepted, during post-trigger filling or after `done`, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arm | input | 1 | Restart capture pulse |
| mode_event | input | 1 | 0 = manual capture, 1 = event capture |
| man_trig | input | 1 | User trigger request |
| din | input | 8 | Stream byte |
| din_valid | input | 1 | Byte strobe |
| din_sou | input | 1 | First byte of a unit |
| evt_flags | input | NUM_EVT | Event condition flags |
| evt_en | input | NUM_EVT | Per-flag enable |
| ovh_valid | input | 1 | Overhead tap sample strobe |
| ovh_pos | input | POS_W | Position of the tapped overhead byte |
| ovh_byte | input | 8 | Tapped overhead byte |
| sel_pos | input | POS_W | Overhead position used for triggering |
| chg_en | input | 1 | Enable change trigger |
| chg_mask | input | 8 | Bits compared by the change trigger |
| val_en | input | 1 | Enable value trigger |
| match_val | input | 8 | Value for the value trigger |
| rd_unit | input | $clog2(DEPTH) | Read unit, 0 = oldest |
| rd_byte | input | $clog2(UNIT_BYTES) | Read byte within unit |
| rd_data | output | 8 | Read data, one cycle latency |
| done | output | 1 | Capture complete |
| trig_idx | output | $clog2(DEPTH) | Ring slot of the trigger unit |

## Verification
The bench builds the block with `DEPTH`=8 and `UNIT_BYTES`=4. With this size, a capture that wraps the ring more than once completes in a few dozen units. It also makes the half-depth arming threshold of four units easy to approach from both sides. Byte values encode the unit sequence number and the byte offset, so every read-back reveals which unit sits in which address. This checks the oldest-first offset after both wrapped and unwrapped fills, and it shows whether a trigger slot or a masked change was mishandled.

// File: rtl/cap_pkg.sv
// Shared types for the unit capture buffer.
// Assumes: nothing beyond IEEE 1800-2017.
package cap_pkg;

    // Capture phase: filling the ring, storing post-trigger units, frozen.
    typedef enum logic [1:0] {
        CAP_FILL = 2'd0,
        CAP_POST = 2'd1,
        CAP_DONE = 2'd2
    } cap_state_e;

endpackage

// File: rtl/cap_trigger.sv
// Trigger qualifier. In manual mode it passes the user request through.
// In event mode it combines enabled event flags, a masked change test and a
// value match on one selected overhead byte position.
// Assumes: the overhead tap delivers at most one byte per cycle, and arm
// clears the stored previous sample.
module cap_trigger #(
    parameter int NUM_EVT = 4,
    parameter int POS_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               arm,
    input  logic               mode_event,
    input  logic               man_trig,
    input  logic [NUM_EVT-1:0] evt_flags,
    input  logic [NUM_EVT-1:0] evt_en,
    input  logic               ovh_valid,
    input  logic [POS_W-1:0]   ovh_pos,
    input  logic [7:0]         ovh_byte,
    input  logic [POS_W-1:0]   sel_pos,
    input  logic               chg_en,
    input  logic [7:0]         chg_mask,
    input  logic               val_en,
    input  logic [7:0]         match_val,
    output logic               trig_req
);

    logic [7:0] prev_byte;
    logic       prev_ok;
    logic       tap_hit;
    logic       chg_hit;
    logic       val_hit;
    logic       evt_hit;

    // Qualify each trigger source and select by mode.
    always_comb begin
        tap_hit  = ovh_valid && (ovh_pos == sel_pos);
        chg_hit  = chg_en && tap_hit && prev_ok && (((ovh_byte ^ prev_byte) & chg_mask) != 8'd0);
        val_hit  = val_en && tap_hit && (ovh_byte == match_val);
        evt_hit  = |(evt_flags & evt_en);
        trig_req = mode_event ? (evt_hit || chg_hit || val_hit) : man_trig;
    end

    // Remember the last sample of the selected byte for the change test.
    always_ff @(posedge clk) begin
        if (!rst_n || arm) begin
            prev_byte <= 8'd0;
            prev_ok   <= 1'b0;
        end else if (tap_hit) begin
            prev_byte <= ovh_byte;
            prev_ok   <= 1'b1;
        end
    end

endmodule

// File: rtl/cap_ctrl.sv
// Capture controller. It frames units on the start strobe, steps the ring
// slot pointer, counts stored and post-trigger units, accepts the trigger
// and freezes the ring when the post-trigger count is reached.
// Assumes: mode_event is held steady from arm until done, DEPTH is even
// and at least 2, and UNIT_BYTES is at least 2.
module cap_ctrl #(
    parameter int DEPTH      = 16,
    parameter int UNIT_BYTES = 8,
    localparam int UW        = $clog2(DEPTH),
    localparam int BW        = $clog2(UNIT_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic          mode_event,
    input  logic          trig_req,
    input  logic          din_valid,
    input  logic          din_sou,
    output logic          wr_en,
    output logic [UW-1:0] wr_unit,
    output logic [BW-1:0] wr_byte,
    output logic          done,
    output logic [UW-1:0] trig_idx
);
    import cap_pkg::*;

    localparam int CW   = $clog2(DEPTH + 1);
    localparam int HALF = DEPTH / 2;

    cap_state_e    state;
    logic [UW-1:0] wr_ptr;
    logic [BW-1:0] byte_idx;
    logic          in_unit;
    logic [CW-1:0] stored_cnt;
    logic [CW-1:0] post_cnt;
    logic [CW-1:0] target;
    logic          unit_done;
    logic          accept;

    // Write qualification, unit completion and trigger acceptance.
    always_comb begin
        wr_en     = (state != CAP_DONE) && !arm && din_valid && (din_sou || in_unit);
        unit_done = wr_en && !din_sou && (byte_idx == BW'(UNIT_BYTES - 1));
        target    = mode_event ? CW'(HALF) : CW'(DEPTH);
        accept    = (state == CAP_FILL) && !arm && trig_req &&
                    (!mode_event || (stored_cnt >= CW'(HALF)));
        wr_unit   = wr_ptr;
        wr_byte   = din_sou ? '0 : byte_idx;
        done      = (state == CAP_DONE);
    end

    // Unit framing and ring pointer stepping.
    always_ff @(posedge clk) begin
        if (!rst_n || arm) begin
            wr_ptr     <= '0;
            byte_idx   <= '0;
            in_unit    <= 1'b0;
            stored_cnt <= '0;
        end else if (wr_en) begin
            if (din_sou) begin
                byte_idx <= BW'(1);
                in_unit  <= 1'b1;
            end else if (unit_done) begin
                byte_idx <= '0;
                in_unit  <= 1'b0;
                wr_ptr   <= (wr_ptr == UW'(DEPTH - 1)) ? '0 : wr_ptr + UW'(1);
                if (stored_cnt < CW'(DEPTH)) begin
                    stored_cnt <= stored_cnt + CW'(1);
                end
            end else begin
                byte_idx <= byte_idx + BW'(1);
            end
        end
    end

    // Capture phase sequencing and post-trigger counting.
    always_ff @(posedge clk) begin
        if (!rst_n || arm) begin
            state    <= CAP_FILL;
            post_cnt <= '0;
        end else begin
            case (state)
                CAP_FILL: if (accept) begin
                    post_cnt <= unit_done ? CW'(1) : CW'(0);
                    state    <= (unit_done && target == CW'(1)) ? CAP_DONE : CAP_POST;
                end
                CAP_POST: if (unit_done) begin
                    post_cnt <= post_cnt + CW'(1);
                    if (post_cnt + CW'(1) == target) begin
                        state <= CAP_DONE;
                    end
                end
                default: state <= CAP_DONE;
            endcase
        end
    end

    // Latch the ring slot of the trigger unit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_idx <= '0;
        end else if (accept) begin
            trig_idx <= wr_ptr;
        end
    end

    // R4: no trigger accepted in event mode before the pre-trigger half is full.
    p_pre_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CAP_FILL && mode_event && stored_cnt < CW'(HALF)) |=> (state == CAP_FILL));

    // R3: the post-trigger count never passes its target.
    p_post_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CAP_POST) |-> (post_cnt < target));

    // R10 and R11: the trigger slot is held once a trigger has been accepted.
    p_trig_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state != CAP_FILL) |=> $stable(trig_idx));

    // R8: the ring freezes only on a unit completion.
    p_freeze_on_unit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == CAP_DONE) |-> $past(unit_done));

endmodule

// File: rtl/cap_mem.sv
// Byte store for the capture ring, with one write port and one registered
// read port.
// Assumes: addresses are in range, and a read of the byte being written in
// the same cycle returns the old content.
module cap_mem #(
    parameter int WORDS = 128,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    logic [7:0] store [WORDS];

    // Store write.
    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    // Registered read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= 8'd0;
        end else begin
            rdata <= store[raddr];
        end
    end

endmodule

// File: rtl/cap_buffer.sv
// Top of the pre/post-trigger unit capture buffer. It connects the trigger
// qualifier, the controller and the byte store, and maps read addresses so
// that unit 0 is the oldest stored unit.
// Assumes: rd_unit < DEPTH and rd_byte < UNIT_BYTES. The production sizes
// are 1500 or 256 units of the unit length in bytes.
module cap_buffer #(
    parameter int DEPTH      = 16,
    parameter int UNIT_BYTES = 8,
    parameter int NUM_EVT    = 4,
    parameter int POS_W      = 6,
    localparam int UW        = $clog2(DEPTH),
    localparam int BW        = $clog2(UNIT_BYTES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               arm,
    input  logic               mode_event,
    input  logic               man_trig,
    input  logic [7:0]         din,
    input  logic               din_valid,
    input  logic               din_sou,
    input  logic [NUM_EVT-1:0] evt_flags,
    input  logic [NUM_EVT-1:0] evt_en,
    input  logic               ovh_valid,
    input  logic [POS_W-1:0]   ovh_pos,
    input  logic [7:0]         ovh_byte,
    input  logic [POS_W-1:0]   sel_pos,
    input  logic               chg_en,
    input  logic [7:0]         chg_mask,
    input  logic               val_en,
    input  logic [7:0]         match_val,
    input  logic [UW-1:0]      rd_unit,
    input  logic [BW-1:0]      rd_byte,
    output logic [7:0]         rd_data,
    output logic               done,
    output logic [UW-1:0]      trig_idx
);

    localparam int WORDS = DEPTH * UNIT_BYTES;
    localparam int AW    = $clog2(WORDS);

    logic          trig_req;
    logic          wr_en;
    logic [UW-1:0] wr_unit;
    logic [BW-1:0] wr_byte;
    logic [UW:0]   rd_sum;
    logic [UW-1:0] rd_slot;
    logic [AW-1:0] waddr;
    logic [AW-1:0] raddr;

    cap_trigger #(.NUM_EVT(NUM_EVT), .POS_W(POS_W)) u_trig (
        .clk(clk), .rst_n(rst_n), .arm(arm), .mode_event(mode_event),
        .man_trig(man_trig), .evt_flags(evt_flags), .evt_en(evt_en),
        .ovh_valid(ovh_valid), .ovh_pos(ovh_pos), .ovh_byte(ovh_byte),
        .sel_pos(sel_pos), .chg_en(chg_en), .chg_mask(chg_mask),
        .val_en(val_en), .match_val(match_val), .trig_req(trig_req)
    );

    cap_ctrl #(.DEPTH(DEPTH), .UNIT_BYTES(UNIT_BYTES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .arm(arm), .mode_event(mode_event),
        .trig_req(trig_req), .din_valid(din_valid), .din_sou(din_sou),
        .wr_en(wr_en), .wr_unit(wr_unit), .wr_byte(wr_byte),
        .done(done), .trig_idx(trig_idx)
    );

    // Byte addresses. Read unit 0 starts at the next write slot, which is
    // the oldest unit once the ring is full.
    always_comb begin
        rd_sum  = {1'b0, wr_unit} + {1'b0, rd_unit};
        rd_slot = (rd_sum >= (UW+1)'(DEPTH)) ? UW'(rd_sum - (UW+1)'(DEPTH)) : UW'(rd_sum);
        waddr   = AW'(int'(wr_unit) * UNIT_BYTES + int'(wr_byte));
        raddr   = AW'(int'(rd_slot) * UNIT_BYTES + int'(rd_byte));
    end

    cap_mem #(.WORDS(WORDS)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(wr_en), .waddr(waddr), .wdata(din),
        .raddr(raddr), .rdata(rd_data)
    );

    // R8: done holds until arm.
    p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !arm) |=> done);

    // R8: arm clears done.
    p_arm_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> !done);

endmodule

// File: tb/tb_cap_buffer.sv
`timescale 1ns/1ps
module tb_cap_buffer;

    localparam int D   = 8;
    localparam int UB  = 4;
    localparam int H   = D / 2;
    localparam logic [5:0] SEL = 6'd3;

    // Vector: [7] event mode, [6:5] trigger kind (0 manual, 1 flag,
    // 2 change, 3 value), [4:0] index of the trigger unit since arm.
    localparam logic [7:0] VEC [6] = '{8'h00, 8'h05, 8'hA4, 8'hC6, 8'hE9, 8'h0A};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       arm = 1'b0;
    logic       mode_event = 1'b0;
    logic       man_trig = 1'b0;
    logic [7:0] din = 8'd0;
    logic       din_valid = 1'b0;
    logic       din_sou = 1'b0;
    logic [3:0] evt_flags = 4'd0;
    logic [3:0] evt_en = 4'b0100;
    logic       ovh_valid = 1'b0;
    logic [5:0] ovh_pos = 6'd0;
    logic [7:0] ovh_byte = 8'd0;
    logic       chg_en = 1'b0;
    logic       val_en = 1'b0;
    logic [2:0] rd_unit = 3'd0;
    logic [1:0] rd_byte = 2'd0;
    logic [7:0] rd_data;
    logic       done;
    logic [2:0] trig_idx;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    cap_buffer #(.DEPTH(D), .UNIT_BYTES(UB), .NUM_EVT(4), .POS_W(6)) dut (
        .clk(clk), .rst_n(rst_n), .arm(arm), .mode_event(mode_event),
        .man_trig(man_trig), .din(din), .din_valid(din_valid), .din_sou(din_sou),
        .evt_flags(evt_flags), .evt_en(evt_en), .ovh_valid(ovh_valid),
        .ovh_pos(ovh_pos), .ovh_byte(ovh_byte), .sel_pos(SEL),
        .chg_en(chg_en), .chg_mask(8'h0F), .val_en(val_en), .match_val(8'h5A),
        .rd_unit(rd_unit), .rd_byte(rd_byte), .rd_data(rd_data),
        .done(done), .trig_idx(trig_idx)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_arm();
        arm = 1'b1;
        step();
        arm = 1'b0;
    endtask

    // One unit. tk: -1 none, 0 manual, 1 enabled flag, 2 in-mask change,
    // 3 value match, 4 out-of-mask change, 5 match at wrong position,
    // 6 disabled flag.
    task automatic send_unit(input int seq, input int tk);
        for (int b = 0; b < UB; b++) begin
            din       = 8'(seq * UB + b);
            din_valid = 1'b1;
            din_sou   = (b == 0);
            ovh_valid = (b == 0);
            ovh_pos   = (b == 0 && tk == 5) ? SEL + 6'd1 : SEL;
            ovh_byte  = (tk == 2) ? 8'h11 : (tk == 3 || tk == 5) ? 8'h5A :
                        (tk == 4) ? 8'h30 : 8'h10;
            man_trig  = (b == 0 && tk == 0);
            evt_flags = (b == 0 && tk == 1) ? 4'b0100 : (b == 0 && tk == 6) ? 4'b0010 : 4'd0;
            step();
        end
        din_valid = 1'b0;
        din_sou   = 1'b0;
        ovh_valid = 1'b0;
        man_trig  = 1'b0;
        evt_flags = 4'd0;
    endtask

    task automatic send_range(input int first, input int last);
        for (int s = first; s <= last; s++) send_unit(s, -1);
    endtask

    task automatic read_byte(input int u, input int b, output int v);
        rd_unit = 3'(u);
        rd_byte = 2'(b);
        step();
        v = int'(rd_data);
    endtask

    // Read all units; address u must hold unit first+u.
    task automatic check_content(input int first, input string req);
        for (int u = 0; u < D; u++) begin
            int got;
            int bad_act = 0;
            int bad_exp = 0;
            bit ok = 1'b1;
            for (int b = 0; b < UB; b++) begin
                read_byte(u, b, got);
                if (ok && got != (first + u) * UB + b) begin
                    ok = 1'b0;
                    bad_act = got;
                    bad_exp = (first + u) * UB + b;
                end
            end
            chk(ok, req, bad_act, bad_exp);
        end
    endtask

    initial begin
        #1000000;
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1: reset state
        chk(done == 1'b0, "R1 done", int'(done), 0);
        chk(trig_idx == 3'd0, "R1 trig_idx", int'(trig_idx), 0);
        chk(rd_data == 8'd0, "R1 rd_data", int'(rd_data), 0);

        // Table of trigger scenarios.
        for (int i = 0; i < 6; i++) begin
            bit ev = VEC[i][7];
            int kind = int'(VEC[i][6:5]);
            int k = int'(VEC[i][4:0]);
            int total = ev ? k + H : k + D;
            mode_event = ev;
            chg_en = (kind == 2);
            val_en = (kind == 3);
            do_arm();
            send_range(0, k - 1);
            send_unit(k, kind);
            send_range(k + 1, total - 2);
            chk(done == 1'b0, ev ? "R4 done early" : "R3 done early", int'(done), 0);
            send_unit(total - 1, -1);
            chk(done == 1'b1, ev ? "R4 done" : "R3 done", int'(done), 1);
            chk(trig_idx == 3'(k % D), "R10 trig_idx", int'(trig_idx), k % D);
            check_content(ev ? k - H : k, ev ? "R4 R9 content" : "R3 R9 content");
        end

        // R4: early event trigger ignored, later one accepted.
        mode_event = 1'b1; chg_en = 1'b0; val_en = 1'b0;
        do_arm();
        send_unit(0, -1);
        send_unit(1, 1);
        send_range(2, 13);
        chk(done == 1'b0, "R4 early trigger ignored", int'(done), 0);
        send_unit(14, 1);
        send_range(15, 17);
        chk(done == 1'b1, "R4 late trigger", int'(done), 1);
        chk(trig_idx == 3'd6, "R10 trig_idx late", int'(trig_idx), 6);
        check_content(10, "R4 content late");

        // R5: manual request ignored in event mode; disabled flag ignored.
        do_arm();
        send_range(0, 4);
        send_unit(5, 0);
        send_unit(6, 6);
        send_range(7, 16);
        chk(done == 1'b0, "R5 event mode ignores man_trig and disabled flag", int'(done), 0);
        // R5: event flag ignored in manual mode.
        mode_event = 1'b0;
        do_arm();
        send_range(0, 4);
        send_unit(5, 1);
        send_range(6, 16);
        chk(done == 1'b0, "R5 manual mode ignores flags", int'(done), 0);

        // R6: change only in masked-out bits is ignored; in-mask change fires.
        mode_event = 1'b1; chg_en = 1'b1;
        do_arm();
        send_range(0, 4);
        send_unit(5, 4);
        send_range(6, 15);
        chk(done == 1'b0, "R6 masked change ignored", int'(done), 0);
        send_unit(16, 2);
        send_range(17, 18);
        chk(done == 1'b0, "R6 post phase", int'(done), 0);
        send_unit(19, -1);
        chk(done == 1'b1, "R6 change trigger", int'(done), 1);
        chk(trig_idx == 3'd0, "R6 trig_idx", int'(trig_idx), 0);
        check_content(12, "R6 content");

        // R7: value at a non-selected position ignored.
        chg_en = 1'b0; val_en = 1'b1;
        do_arm();
        send_range(0, 4);
        send_unit(5, 5);
        send_range(6, 15);
        chk(done == 1'b0, "R7 wrong position ignored", int'(done), 0);

        // R2 and R11: stray bytes, mid-unit restart, second trigger ignored.
        mode_event = 1'b0; val_en = 1'b0;
        do_arm();
        send_unit(0, 0);
        din = 8'hFF; din_valid = 1'b1; din_sou = 1'b0;
        step(); step();
        din = 8'hEE; din_sou = 1'b1;
        step();
        din_sou = 1'b0;
        step();
        din_valid = 1'b0;
        send_unit(1, -1);
        send_range(2, 2);
        send_unit(3, 0);
        send_range(4, 6);
        chk(done == 1'b0, "R11 second trigger ignored", int'(done), 0);
        send_unit(7, -1);
        chk(done == 1'b1, "R11 done on first trigger count", int'(done), 1);
        chk(trig_idx == 3'd0, "R11 trig_idx kept", int'(trig_idx), 0);
        check_content(0, "R2 framing");

        // R8: frozen after done, then arm clears.
        send_range(40, 41);
        chk(done == 1'b1, "R8 done held", int'(done), 1);
        check_content(0, "R8 no writes after done");
        do_arm();
        chk(done == 1'b0, "R8 arm clears done", int'(done), 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule